// File: doc/BRIEF.md
# I2S Stereo Transmitter with Frame-Safe Pause

This block is the transmit side of a single stereo I2S link. It runs as the clock master and generates the serial bit clock and the word-select clock itself. It takes packed sample words from an internal transmit FIFO and shifts them out on the serial data line, most significant bit first. The sample length can be set from 4 to 32 bits. Short samples (16 bits or fewer) are packed two to a FIFO word. Longer samples take one FIFO word per channel. An optional swap exchanges left and right when a word is unpacked, and a mono setting sends FIFO data on the left channel only.

Software can stop the flow between the FIFO and the serializer, for example to flush or refill the FIFO. It raises a pause request and then waits for the paused flag before it touches the FIFO. The frame already on the wire is always completed. The flag rises only when the serializer has reached a frame boundary with no data in flight. When the request is removed, data restarts at the next frame boundary, never in the middle of a frame. While the block is paused or starved, the data line carries zeros and both clocks keep running. A sticky underflow flag records any frame boundary that found no sample ready while the flow was enabled.

The pause control is a four-state machine:
- ST_RUN: data flows normally. From ST_RUN, a request moves the machine to ST_DRAIN. If the request arrives in the frame-boundary cycle, the machine goes straight to ST_PAUSED.
- ST_DRAIN: the current frame finishes. A frame boundary moves the machine to ST_PAUSED. Dropping the request returns it to ST_RUN.
- ST_PAUSED: the flow is stopped. Dropping the request moves the machine to ST_RESUME.
- ST_RESUME: the machine waits for a frame boundary, then moves to ST_RUN. Raising the request again returns it to ST_PAUSED.

The paused flag is high in ST_PAUSED and ST_RESUME.

Top module: `i2s_tx`

## Requirements
- R1: SD and WS change only on SCK falling edges. WS is 0 for the left channel and 1 for the right channel. Each channel carries exactly cfg_len bits, MSB first. The MSB appears one SCK period after the WS edge that opens that channel.
- R2: With cfg_len of 16 or less, cfg_mono=0 and cfg_right_low=0, one FIFO word makes one frame. The left sample is taken from bits 15:0 and the right sample from bits 31:16. In each half, only the low cfg_len bits are used.
- R3: With cfg_len above 16 and cfg_mono=0, each frame takes two consecutive FIFO words. The first word is the left sample and the second is the right sample. In each word, the low cfg_len bits are used.
- R4: With cfg_right_low=1, cfg_mono=0 and cfg_len of 24 or less, left and right are exchanged. For packed words, the left sample comes from bits 31:16 and the right sample from bits 15:0. For two-word frames, the first word goes to the right channel.
- R5: With cfg_len above 24, cfg_right_low has no effect: the first word is left and the second is right.
- R6: With cfg_mono=1, each frame takes exactly one FIFO word. The left sample comes from bits 15:0 (packed lengths) or from the low cfg_len bits (longer lengths). The right channel carries zeros, and cfg_right_low has no effect.
- R7: Once the pause is in effect, no FIFO word reaches SD. Words written to the FIFO while paused are sent, in order, only after the pause ends.
- R8: After pause_req rises, the frame in flight completes. paused rises only on the SCK falling edge that ends a frame, which is also the edge where WS falls. If pause_req is already high in the cycle of that edge, paused rises on that same edge.
- R9: After pause_req falls, paused falls on the next frame-ending SCK falling edge. The first frame sent after that edge is a complete, correctly ordered frame.
- R10: While paused, or while no sample is ready, SD is 0 for whole frames, and SCK and WS keep toggling.
- R11: underflow is set at a frame boundary that finds no sample ready while the flow is not paused. It is never set by paused frames. It stays set until underflow_clr is pulsed.
- R12: While rst_n is low and directly after reset, sck, ws, sd, paused and underflow are 0, and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_len | input | 6 | Sample length in bits, clamped to 4..32 |
| cfg_mono | input | 1 | Send FIFO data on the left channel only |
| cfg_right_low | input | 1 | Swap left and right when unpacking FIFO words |
| pause_req | input | 1 | Request to stop the FIFO-to-serializer flow |
| wr_valid | input | 1 | Write strobe into the transmit FIFO |
| wr_data | input | 32 | FIFO write word |
| fifo_full | output | 1 | FIFO cannot take a word this cycle |
| underflow_clr | input | 1 | Clears the sticky underflow flag |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select, 0 = left channel |
| sd | output | 1 | Serial data |
| paused | output | 1 | Pause is actually in effect |
| underflow | output | 1 | Sticky flag: a frame boundary found no sample |

## Verification
A pause request and a frame boundary can land in the same clock cycle. In that case the machine must go from ST_RUN directly to ST_PAUSED and must not load a new frame. The bench provokes this by finding a falling WS edge, counting one frame minus one cycle, and raising pause_req so that it is sampled on the next wrap. It judges the result by requiring paused high right after that edge, with the following frame carrying zeros. Data continuity is also checked afterwards: every frame deserialized from SD must match the next expected pair in the reference queue, across the pause and the resume.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_PAUSED = 2'd2,
        ST_RESUME = 2'd3
    } pause_state_e;

    localparam int unsigned WORD_W       = 32;
    localparam int unsigned HALF_W       = WORD_W / 2;
    localparam int unsigned MIN_LEN      = 4;
    localparam int unsigned SWAP_MAX_LEN = 24;

endpackage

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic             empty,
    output logic             full
);

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push;
    logic             do_pop;

    assign empty    = (count == '0);
    assign full     = (count == CW'(DEPTH));
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign pop_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R10

endmodule

// File: rtl/i2s_tx_sckgen.sv
module i2s_tx_sckgen #(
    parameter int unsigned SCK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic sck,
    output logic fall_tick
);

    localparam int unsigned CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

    logic [CW-1:0] cnt;
    logic          last;

    assign last      = (cnt == CW'(SCK_HALF - 1));
    assign fall_tick = last && sck;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (last) begin
            cnt <= '0;
            sck <= ~sck;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/i2s_tx_serdes.sv
module i2s_tx_serdes #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned LEN_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_tick,
    input  logic [LEN_W-1:0]  len,
    input  logic              load,
    input  logic [WORD_W-1:0] l_in,
    input  logic [WORD_W-1:0] r_in,
    output logic              ws,
    output logic              sd,
    output logic              wrap
);

    localparam int unsigned PW = LEN_W + 1;
    localparam int unsigned IW = $clog2(WORD_W);

    logic [PW-1:0]     pos;
    logic [PW-1:0]     pos_nxt;
    logic [PW-1:0]     len_x;
    logic [PW-1:0]     last_pos;
    logic [PW-1:0]     idx;
    logic              cur_bit;
    logic [WORD_W-1:0] frame_l;
    logic [WORD_W-1:0] frame_r;

    assign len_x    = {1'b0, len};
    assign last_pos = (len_x << 1) - PW'(1);
    assign wrap     = fall_tick && (pos >= last_pos);
    assign pos_nxt  = wrap ? '0 : pos + PW'(1);

    always_comb begin
        if (pos < len_x) begin
            idx     = len_x - PW'(1) - pos;
            cur_bit = frame_l[idx[IW-1:0]];
        end else begin
            idx     = last_pos - pos;
            cur_bit = frame_r[idx[IW-1:0]];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos     <= '0;
            ws      <= 1'b0;
            sd      <= 1'b0;
            frame_l <= '0;
            frame_r <= '0;
        end else if (fall_tick) begin
            pos <= pos_nxt;
            ws  <= (pos_nxt >= len_x);
            sd  <= cur_bit;
            if (wrap) begin
                frame_l <= load ? l_in : '0;
                frame_r <= load ? r_in : '0;
            end
        end
    end

    AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_tick |=> $stable(sd)); // R1
    AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_tick |=> $stable(ws)); // R1

endmodule

// File: rtl/i2s_tx.sv
module i2s_tx
    import i2s_tx_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 8,
    parameter int unsigned SCK_HALF   = 2,
    parameter int unsigned LEN_W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_mono,
    input  logic              cfg_right_low,
    input  logic              pause_req,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              fifo_full,
    input  logic              underflow_clr,
    output logic              sck,
    output logic              ws,
    output logic              sd,
    output logic              paused,
    output logic              underflow
);

    localparam logic [LEN_W-1:0] LEN_LO   = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] LEN_HI   = LEN_W'(WORD_W);
    localparam logic [LEN_W-1:0] LEN_PACK = LEN_W'(HALF_W);
    localparam logic [LEN_W-1:0] LEN_SWAP = LEN_W'(SWAP_MAX_LEN);

    pause_state_e      state;
    pause_state_e      state_d;
    logic [LEN_W-1:0]  len_eff;
    logic              packed_mode;
    logic              two_words;
    logic              swap;
    logic              fall_tick;
    logic              wrap;
    logic              fifo_empty;
    logic [WORD_W-1:0] fifo_word;
    logic              pop;
    logic              flowing;
    logic              go;
    logic              uf_set;
    logic              stage_valid;
    logic              have_first;
    logic [WORD_W-1:0] first_word;
    logic [WORD_W-1:0] stage_l;
    logic [WORD_W-1:0] stage_r;
    logic [WORD_W-1:0] lo_half;
    logic [WORD_W-1:0] hi_half;

    // configuration decode
    always_comb begin
        if (cfg_len < LEN_LO) begin
            len_eff = LEN_LO;
        end else if (cfg_len > LEN_HI) begin
            len_eff = LEN_HI;
        end else begin
            len_eff = cfg_len;
        end
    end

    assign packed_mode = (len_eff <= LEN_PACK);
    assign two_words   = !packed_mode && !cfg_mono;
    assign swap        = cfg_right_low && !cfg_mono && (len_eff <= LEN_SWAP);
    assign lo_half     = {{HALF_W{1'b0}}, fifo_word[HALF_W-1:0]};
    assign hi_half     = {{HALF_W{1'b0}}, fifo_word[WORD_W-1:HALF_W]};

    i2s_tx_fifo #(
        .WIDTH (WORD_W),
        .DEPTH (FIFO_DEPTH)
    ) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_valid),
        .push_data (wr_data),
        .pop       (pop),
        .pop_data  (fifo_word),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    i2s_tx_sckgen #(
        .SCK_HALF (SCK_HALF)
    ) i_sckgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck       (sck),
        .fall_tick (fall_tick)
    );

    i2s_tx_serdes #(
        .WORD_W (WORD_W),
        .LEN_W  (LEN_W)
    ) i_serdes (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_tick (fall_tick),
        .len       (len_eff),
        .load      (go),
        .l_in      (stage_l),
        .r_in      (stage_r),
        .ws        (ws),
        .sd        (sd),
        .wrap      (wrap)
    );

    // pause state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_d;
        end
    end

    // pause transitions
    always_comb begin
        state_d = state;
        unique case (state)
            ST_RUN: begin
                if (pause_req) begin
                    state_d = wrap ? ST_PAUSED : ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (!pause_req) begin
                    state_d = ST_RUN;
                end else if (wrap) begin
                    state_d = ST_PAUSED;
                end
            end
            ST_PAUSED: begin
                if (!pause_req) begin
                    state_d = ST_RESUME;
                end
            end
            ST_RESUME: begin
                if (pause_req) begin
                    state_d = ST_PAUSED;
                end else if (wrap) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // state outputs
    always_comb begin
        flowing = !pause_req && (state != ST_PAUSED);
        paused  = (state == ST_PAUSED) || (state == ST_RESUME);
        go      = wrap && flowing && stage_valid;
        uf_set  = wrap && flowing && !stage_valid;
        pop     = flowing && !stage_valid && !fifo_empty;
    end

    // staging of one complete frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_valid <= 1'b0;
            have_first  <= 1'b0;
            first_word  <= '0;
            stage_l     <= '0;
            stage_r     <= '0;
        end else if (go) begin
            stage_valid <= 1'b0;
        end else if (pop) begin
            if (two_words) begin
                if (!have_first) begin
                    first_word <= fifo_word;
                    have_first <= 1'b1;
                end else begin
                    stage_l     <= swap ? fifo_word : first_word;
                    stage_r     <= swap ? first_word : fifo_word;
                    have_first  <= 1'b0;
                    stage_valid <= 1'b1;
                end
            end else if (packed_mode) begin
                stage_l     <= swap ? hi_half : lo_half;
                stage_r     <= cfg_mono ? '0 : (swap ? lo_half : hi_half);
                stage_valid <= 1'b1;
            end else begin
                stage_l     <= fifo_word;
                stage_r     <= '0;
                stage_valid <= 1'b1;
            end
        end
    end

    // sticky underflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            underflow <= 1'b0;
        end else if (uf_set) begin
            underflow <= 1'b1;
        end else if (underflow_clr) begin
            underflow <= 1'b0;
        end
    end

    AST_PAUSE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paused) |-> (!sck && !ws)); // R8
    AST_RESUME_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(paused) |-> (!sck && !ws)); // R9
    AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !underflow_clr) |=> underflow); // R11
    AST_NO_LOAD_WHILE_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && pause_req) |-> !pop); // R7

endmodule

// File: tb/test_i2s_tx.sv
module test_i2s_tx;

    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cfg_len = 6'd16;
    logic        cfg_mono = 1'b0;
    logic        cfg_right_low = 1'b0;
    logic        pause_req = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        underflow_clr = 1'b0;
    logic        fifo_full, sck, ws, sd, paused, underflow;

    always #2.5 clk = ~clk;

    i2s_tx #(.FIFO_DEPTH(8), .SCK_HALF(HALF), .LEN_W(6)) i_i2s_tx (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_mono(cfg_mono),
        .cfg_right_low(cfg_right_low), .pause_req(pause_req),
        .wr_valid(wr_valid), .wr_data(wr_data), .fifo_full(fifo_full),
        .underflow_clr(underflow_clr), .sck(sck), .ws(ws), .sd(sd),
        .paused(paused), .underflow(underflow)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int word_k = 0;
    int data_frames = 0;
    int idle_frames = 0;
    int sck_rises = 0;
    logic [31:0] exp_l[$];
    logic [31:0] exp_r[$];
    string       exp_tag[$];

    logic [31:0] acc_l, acc_r;
    int          cnt_l, cnt_r;
    logic        prev_ws, sck_q, paused_q;

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] msk(logic [31:0] v);
        if (cfg_len >= 6'd32) return v;
        return v & ((32'h1 << cfg_len) - 32'h1);
    endfunction

    function automatic logic [31:0] gen(int k);
        logic [7:0] b;
        b = 8'(k);
        return {8'hC0 | b, 8'h5A ^ b, b[3:0], 4'h7, b[3:0], 4'h9};
    endfunction

    task automatic frame_done();
        logic [31:0] l, r, el, er;
        string t;
        l = msk(acc_l);
        r = msk(acc_r);
        if (l == 0 && r == 0) begin
            idle_frames++;
        end else begin
            data_frames++;
            check(cnt_l == int'(cfg_len) && cnt_r == int'(cfg_len), "R1 bit count",
                  {cnt_l, cnt_r}, longint'(cfg_len));
            if (exp_l.size() == 0) begin
                check(1'b0, "R7 unexpected frame", {l, r}, 0);
            end else begin
                el = exp_l.pop_front();
                er = exp_r.pop_front();
                t  = exp_tag.pop_front();
                check(l == el && r == er, t, {l, r}, {el, er});
            end
        end
        acc_l = '0; acc_r = '0; cnt_l = 0; cnt_r = 0;
    endtask

    // deserializer and boundary observer
    always @(negedge clk) begin
        if (!rst_n) begin
            acc_l = '0; acc_r = '0; cnt_l = 0; cnt_r = 0;
            prev_ws = 1'b0; sck_q = 1'b0; paused_q = 1'b0;
        end else begin
            if (paused && !paused_q)
                check(!sck && !ws && sck_q, "R8 paused rises at wrap", {sck, ws, sck_q}, 3'b001);
            if (!paused && paused_q)
                check(!sck && !ws && sck_q, "R9 paused falls at wrap", {sck, ws, sck_q}, 3'b001);
            if (sck && !sck_q) begin
                sck_rises++;
                if (prev_ws) begin
                    acc_r = {acc_r[30:0], sd}; cnt_r++;
                end else begin
                    acc_l = {acc_l[30:0], sd}; cnt_l++;
                end
                if (ws != prev_ws && prev_ws) frame_done();
                prev_ws = ws;
            end
            sck_q = sck;
            paused_q = paused;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 180000) begin
            errors++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 180000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic push_word(logic [31:0] w);
        while (fifo_full) @(negedge clk);
        wr_valid = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic push_frame(string tag);
        logic [31:0] w0, w1;
        bit sw;
        w0 = gen(word_k);
        w1 = gen(word_k + 1);
        word_k += 2;
        if (cfg_len <= 6'd16) begin
            sw = cfg_right_low && !cfg_mono;
            if (cfg_mono) begin
                exp_l.push_back(msk({16'h0, w0[15:0]})); exp_r.push_back('0);
            end else begin
                exp_l.push_back(msk(sw ? {16'h0, w0[31:16]} : {16'h0, w0[15:0]}));
                exp_r.push_back(msk(sw ? {16'h0, w0[15:0]} : {16'h0, w0[31:16]}));
            end
            exp_tag.push_back(tag);
            push_word(w0);
        end else if (cfg_mono) begin
            exp_l.push_back(msk(w0)); exp_r.push_back('0); exp_tag.push_back(tag);
            push_word(w0);
        end else begin
            sw = cfg_right_low && (cfg_len <= 6'd24);
            exp_l.push_back(msk(sw ? w1 : w0));
            exp_r.push_back(msk(sw ? w0 : w1));
            exp_tag.push_back(tag);
            push_word(w0);
            push_word(w1);
        end
    endtask

    // pause_mode: 0 none, 1 at an arbitrary cycle, 2 landing on the wrap cycle
    task automatic run_config(int len, bit mono, bit rl, string tag, int nfr, int pause_mode);
        int fclk;
        int n0, i0, s0, pushed;
        logic pw;
        fclk = 4 * len * HALF;
        pause_req = 1'b0; underflow_clr = 1'b0; wr_valid = 1'b0;
        cfg_len = 6'(len); cfg_mono = mono; cfg_right_low = rl;
        exp_l.delete(); exp_r.delete(); exp_tag.delete();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check({sck, ws, sd, paused, underflow, fifo_full} == 6'b0, "R12 in reset",
              {sck, ws, sd, paused, underflow, fifo_full}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({ws, sd, paused, underflow} == 4'b0, "R12 after reset",
              {ws, sd, paused, underflow}, 0);
        n0 = data_frames;
        for (int i = 0; i < 3; i++) push_frame(tag);
        pushed = 3;
        for (int t = 0; t < fclk * 6 && data_frames == n0; t++) @(negedge clk);
        underflow_clr = 1'b1;
        @(negedge clk);
        underflow_clr = 1'b0;
        if (pause_mode != 0) begin
            if (pause_mode == 2) begin
                pw = ws;
                @(negedge clk);
                while (!(pw && !ws)) begin
                    pw = ws;
                    @(negedge clk);
                end
                repeat (fclk - 1) @(negedge clk);
                pause_req = 1'b1;
                @(negedge clk);
                check(paused, "R8 request on the wrap cycle", paused, 1);
            end else begin
                pause_req = 1'b1;
                for (int t = 0; t < fclk * 3 && !paused; t++) @(negedge clk);
                check(paused, "R8 pause takes effect", paused, 1);
            end
            repeat (8) @(negedge clk);
            n0 = data_frames;
            i0 = idle_frames;
            for (int i = 0; i < 3; i++) push_frame(tag);
            pushed += 3;
            repeat (3 * fclk) @(negedge clk);
            check(data_frames == n0, "R7 no data while paused", data_frames, n0);
            check(idle_frames > i0, "R10 zero frames while paused", idle_frames, i0 + 1);
            check(!underflow, "R11 paused frames do not underflow", underflow, 0);
            pause_req = 1'b0;
            for (int t = 0; t < fclk * 3 && paused; t++) @(negedge clk);
            check(!paused, "R9 pause released", paused, 0);
        end
        for (int i = pushed; i < nfr; i++) push_frame(tag);
        for (int t = 0; t < fclk * (nfr + 4) && exp_l.size() != 0; t++) @(negedge clk);
        check(exp_l.size() == 0, "R9 all frames delivered", exp_l.size(), 0);
        s0 = sck_rises;
        i0 = idle_frames;
        repeat (3 * fclk) @(negedge clk);
        check(underflow, "R11 underflow after drain", underflow, 1);
        check(sck_rises > s0 && idle_frames > i0, "R10 clocks run, SD zero when empty",
              idle_frames - i0, 1);
        while (sck) @(negedge clk);
        while (!sck) @(negedge clk);
        underflow_clr = 1'b1;
        @(negedge clk);
        underflow_clr = 1'b0;
        check(!underflow, "R11 clear", underflow, 0);
    endtask

    initial begin
        run_config(16, 1'b0, 1'b0, "R2", 8, 1);
        run_config(16, 1'b0, 1'b1, "R4 packed swap", 5, 0);
        run_config(8,  1'b1, 1'b1, "R6", 6, 0);
        run_config(24, 1'b0, 1'b1, "R4 long swap", 8, 2);
        run_config(32, 1'b0, 1'b1, "R5", 4, 0);
        run_config(20, 1'b0, 1'b0, "R3", 5, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule